// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Register for a Line Framer

This block turns status levels from a line framer and a transmit buffer into sticky event bits in one 8-bit interrupt status word. Edge detectors watch each status input. An event latches its bit when the matching edge or change is seen. The bit stays set until the processor reads the word. A read returns the word and clears it in the same clock.

A per-bit mask chooses which latched events may drive the interrupt pin and the summary bit. The summary bit feeds a chip-wide interrupt summary word. A global visibility control sets what happens to masked events:

- With visibility on, masked events still latch, so software can poll them.
- With visibility off, masked events are dropped and never latch.

In both cases, masked events never reach the pin or the summary bit.

Status word layout:

| Bit | Event |
|-----|-------|
| 0 | Transmit pool ready |
| 1 | Transmit line status change |
| 2 | Multiframe regained |
| 3 | Frame alignment lost |
| 4 | Frame alignment regained |
| 7:5 | Reserved, always read 0 |

Top module: `irq_status_block`

## Requirements
- R1: A read strobe makes rd_data_o show the status word as it stood before that clock edge. At the same edge, every status bit is cleared, except bits whose event occurs in that same cycle.
- R2: With show_masked_i=1, an event whose mask bit is 1 still sets its status bit.
- R3: A latched status bit whose mask bit is 1 never asserts irq_o and never sets summary_o.
- R4: Bit 3 sets when frame_lost_i goes from 0 to 1.
- R5: Bit 4 sets when frame_lost_i goes from 1 to 0.
- R6: Bit 2 sets when mframe_lost_i goes from 1 to 0, but only while crc_mf_mode_i=1. With crc_mf_mode_i=0 the same edge does nothing.
- R7: Bit 1 sets on a 0-to-1 change of tx_open_i, or on any change of tx_short_i. A 1-to-0 change of tx_open_i does nothing.
- R8: Bit 0 sets in each cycle in which tx_pool_rdy_i is 1. This input is a one-cycle pulse meaning the transmit buffer can take another block of up to 32 bytes.
- R9: With show_masked_i=0, an event whose mask bit is 1 does not latch at all.
- R10: If an event occurs in the same cycle as a read strobe, the event wins. Its bit is still set after the read, and the next read returns it.
- R11: irq_o and summary_o are registered. Each is the OR of all status bits whose mask bit is 0, and each updates at the same clock edge as the status word. irq_o is active high by default; summary_o is always active high.
- R12: A synchronous reset clears the status word, rd_data_o, irq_o and summary_o. The edge detectors load the current input levels, so inputs that are already high at reset release raise no event. Bits 7:5 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_lost_i | input | 1 | Framer has lost frame alignment |
| mframe_lost_i | input | 1 | Framer has lost multiframe alignment |
| crc_mf_mode_i | input | 1 | CRC multiframe format selected |
| tx_open_i | input | 1 | Transmit line open detected |
| tx_short_i | input | 1 | Transmit line short detected |
| tx_pool_rdy_i | input | 1 | One-cycle pulse: transmit buffer can accept a block |
| mask_i | input | 8 | Per-bit mask, 1 = masked |
| show_masked_i | input | 1 | Latch masked events without signalling them |
| rd_stb_i | input | 1 | Read strobe for the status word |
| rd_data_o | output | 8 | Status word captured by the last read |
| irq_o | output | 1 | Interrupt output |
| summary_o | output | 1 | Summary bit for the global interrupt status word |

## Verification
The two functions that can fall in the same clock are the clearing read and the latching of a new event.

The bench provokes this collision in two ways:
1. It raises a read strobe and a transmit-pool pulse in the same cycle, while an older frame-loss bit is already pending.
2. It repeats the collision with an empty word.

The collision is judged correct when both of these hold:
- The read returns only the pre-existing word.
- A second read returns the new event bit alone.

This shows that the new event survived the clear and did not leak into the data read in that cycle.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned B_TPR   = 0;  // transmit pool ready
  localparam int unsigned B_TXL   = 1;  // transmit line change
  localparam int unsigned B_MFR   = 2;  // multiframe regained
  localparam int unsigned B_LOSS  = 3;  // frame alignment lost
  localparam int unsigned B_RGN   = 4;  // frame alignment regained
  localparam int unsigned N_WATCH = 4;  // watched level inputs
  localparam int unsigned W_FLOST = 0;
  localparam int unsigned W_MLOST = 1;
  localparam int unsigned W_OPEN  = 2;
  localparam int unsigned W_SHORT = 3;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  // on reset the detector loads the live level so nothing fires on release
  always_ff @(posedge clk) begin
    if (rst) prev_q <= sig_i;
    else     prev_q <= sig_i;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_edge
      assign rise_o[g] =  sig_i[g] & ~prev_q[g];
      assign fall_o[g] = ~sig_i[g] &  prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/irq_event_gen.sv
module irq_event_gen
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_lost_i,
  input  logic              mframe_lost_i,
  input  logic              crc_mf_mode_i,
  input  logic              tx_open_i,
  input  logic              tx_short_i,
  input  logic              tx_pool_rdy_i,
  output logic [STAT_W-1:0] ev_o
);
  logic [N_WATCH-1:0] lvl, rise, fall;

  always_comb begin
    lvl          = '0;
    lvl[W_FLOST] = frame_lost_i;
    lvl[W_MLOST] = mframe_lost_i;
    lvl[W_OPEN]  = tx_open_i;
    lvl[W_SHORT] = tx_short_i;
  end

  irq_edge_detect #(.W(N_WATCH)) edge_i (
    .clk(clk), .rst(rst), .sig_i(lvl), .rise_o(rise), .fall_o(fall)
  );

  always_comb begin
    ev_o         = '0;
    ev_o[B_LOSS] = rise[W_FLOST];
    ev_o[B_RGN]  = fall[W_FLOST];
    ev_o[B_MFR]  = fall[W_MLOST] & crc_mf_mode_i;
    ev_o[B_TXL]  = rise[W_OPEN] | rise[W_SHORT] | fall[W_SHORT];
    ev_o[B_TPR]  = tx_pool_rdy_i;
  end

  a_r4_loss_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_lost_i) |-> ev_o[B_LOSS]);
  a_r5_rgn_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_lost_i) |-> ev_o[B_RGN]);
  a_r6_mfr_needs_crc: assert property (@(posedge clk) disable iff (rst)
    !crc_mf_mode_i |-> !ev_o[B_MFR]);
  a_r7_txl_change: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_open_i) || !$stable(tx_short_i)) |-> ev_o[B_TXL]);
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] ev_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              show_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] stat_nxt_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] rd_data_o
);
  logic [STAT_W-1:0] stat_q, rd_q, ev_ok;

  genvar g;
  generate
    for (g = 0; g < STAT_W; g++) begin : g_bit
      // a masked event latches only when masked statuses are shown
      assign ev_ok[g]      = ev_i[g] & (~mask_i[g] | show_i);
      assign stat_nxt_o[g] = (stat_q[g] & ~rd_i) | ev_ok[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      rd_q   <= '0;
    end else begin
      stat_q <= stat_nxt_o;
      if (rd_i) rd_q <= stat_q;
    end
  end

  assign stat_o    = stat_q;
  assign rd_data_o = rd_q;

  a_r1_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> ((stat_q & ~$past(ev_ok)) == '0));
  a_r10_event_wins: assert property (@(posedge clk) disable iff (rst)
    (rd_i && ev_ok != '0) |=> ((stat_q & $past(ev_ok)) == $past(ev_ok)));
  a_r2_show_latches: assert property (@(posedge clk) disable iff (rst)
    (show_i && (ev_i & mask_i) != '0) |=>
      ((stat_q & $past(ev_i & mask_i)) == $past(ev_i & mask_i)));
  a_r9_hidden_dropped: assert property (@(posedge clk) disable iff (rst)
    (!show_i && rd_i) |=> ((stat_q & $past(mask_i)) == '0));
endmodule

// File: rtl/irq_status_block.sv
module irq_status_block
  import irq_stat_pkg::*;
#(
  parameter bit IRQ_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_lost_i,
  input  logic              mframe_lost_i,
  input  logic              crc_mf_mode_i,
  input  logic              tx_open_i,
  input  logic              tx_short_i,
  input  logic              tx_pool_rdy_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              show_masked_i,
  input  logic              rd_stb_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              summary_o
);
  logic [STAT_W-1:0] ev, stat_nxt, stat;
  logic              pend_q;

  irq_event_gen evgen_i (
    .clk(clk), .rst(rst),
    .frame_lost_i(frame_lost_i), .mframe_lost_i(mframe_lost_i),
    .crc_mf_mode_i(crc_mf_mode_i), .tx_open_i(tx_open_i),
    .tx_short_i(tx_short_i), .tx_pool_rdy_i(tx_pool_rdy_i),
    .ev_o(ev)
  );

  irq_stat_reg sreg_i (
    .clk(clk), .rst(rst), .ev_i(ev), .mask_i(mask_i),
    .show_i(show_masked_i), .rd_i(rd_stb_i),
    .stat_nxt_o(stat_nxt), .stat_o(stat), .rd_data_o(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= |(stat_nxt & ~mask_i);
  end

  assign summary_o = pend_q;
  assign irq_o     = IRQ_ACTIVE_HIGH ? pend_q : ~pend_q;

  a_r3_masked_silent: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_i) == '1) |-> !summary_o);
  a_r11_unmasked_signals: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~$past(mask_i)) != '0) |-> summary_o);
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    stat[STAT_W-1:B_RGN+1] == '0);
endmodule

// File: tb/irq_status_block_tb_top.sv
module irq_status_block_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_lost = 1'b1, mframe_lost = 1'b0, crc_mode = 1'b0;
  logic       tx_open = 1'b1, tx_short = 1'b0, pool = 1'b0;
  logic [7:0] mask = 8'h00;
  logic       show = 1'b0, rd = 1'b0;
  logic [7:0] rd_data;
  logic       irq, summary;
  int         total = 0, bad = 0;

  always #5 clk = ~clk;

  irq_status_block dut_i (
    .clk(clk), .rst(rst), .frame_lost_i(frame_lost), .mframe_lost_i(mframe_lost),
    .crc_mf_mode_i(crc_mode), .tx_open_i(tx_open), .tx_short_i(tx_short),
    .tx_pool_rdy_i(pool), .mask_i(mask), .show_masked_i(show), .rd_stb_i(rd),
    .rd_data_o(rd_data), .irq_o(irq), .summary_o(summary)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one strobe cycle; returns the captured word
  task automatic do_read(output logic [7:0] d);
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 irq after reset", {7'd0, irq}, 8'h00);
    check("R12 summary after reset", {7'd0, summary}, 8'h00);
    check("R12 rd_data after reset", rd_data, 8'h00);
    do_read(d);
    check("R12 no event from high inputs at release", d, 8'h00);
  endtask

  task automatic t_frame();
    logic [7:0] d;
    @(negedge clk) frame_lost = 1'b0;
    @(negedge clk);
    check("R5 R11 irq on regain", {7'd0, irq}, 8'h01);
    check("R11 summary on regain", {7'd0, summary}, 8'h01);
    do_read(d);
    check("R5 regain bit4", d, 8'h10);
    check("R1 irq cleared by read", {7'd0, irq}, 8'h00);
    do_read(d);
    check("R1 second read empty", d, 8'h00);
    @(negedge clk) frame_lost = 1'b1;
    do_read(d);
    check("R4 loss bit3", d, 8'h08);
  endtask

  task automatic t_mframe();
    logic [7:0] d;
    @(negedge clk) mframe_lost = 1'b1;
    @(negedge clk) mframe_lost = 1'b0;
    do_read(d);
    check("R6 no mframe event without crc mode", d, 8'h00);
    crc_mode = 1'b1;
    @(negedge clk) mframe_lost = 1'b1;
    do_read(d);
    check("R6 no event on mframe loss", d, 8'h00);
    @(negedge clk) mframe_lost = 1'b0;
    do_read(d);
    check("R6 mframe regain bit2", d, 8'h04);
  endtask

  task automatic t_txline();
    logic [7:0] d;
    @(negedge clk) tx_open = 1'b0;
    do_read(d);
    check("R7 open falling ignored", d, 8'h00);
    @(negedge clk) tx_open = 1'b1;
    do_read(d);
    check("R7 open rising bit1", d, 8'h02);
    @(negedge clk) tx_short = 1'b1;
    do_read(d);
    check("R7 short rising bit1", d, 8'h02);
    @(negedge clk) tx_short = 1'b0;
    do_read(d);
    check("R7 short falling bit1", d, 8'h02);
  endtask

  task automatic t_pool();
    logic [7:0] d;
    @(negedge clk) pool = 1'b1;
    @(negedge clk) pool = 1'b0;
    do_read(d);
    check("R8 pool ready bit0", d, 8'h01);
  endtask

  task automatic t_visibility();
    logic [7:0] d;
    mask = 8'h01; show = 1'b1;
    @(negedge clk) pool = 1'b1;
    @(negedge clk) pool = 1'b0;
    check("R3 masked latched no irq", {7'd0, irq}, 8'h00);
    check("R3 masked latched no summary", {7'd0, summary}, 8'h00);
    do_read(d);
    check("R2 masked event latched when shown", d, 8'h01);
    show = 1'b0;
    @(negedge clk) pool = 1'b1;
    @(negedge clk) pool = 1'b0;
    do_read(d);
    check("R9 masked event dropped when hidden", d, 8'h00);
    mask = 8'h00;
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk) frame_lost = 1'b0;
    @(negedge clk) frame_lost = 1'b1;
    @(negedge clk) begin rd = 1'b1; pool = 1'b1; end
    @(negedge clk) begin rd = 1'b0; pool = 1'b0; end
    check("R10 read returns old word only", rd_data, 8'h18);
    check("R10 irq still set after colliding read", {7'd0, irq}, 8'h01);
    do_read(d);
    check("R10 event survives read", d, 8'h01);
    @(negedge clk) begin rd = 1'b1; pool = 1'b1; end
    @(negedge clk) begin rd = 1'b0; pool = 1'b0; end
    check("R10 empty read on collision", rd_data, 8'h00);
    do_read(d);
    check("R10 event survives empty read", d, 8'h01);
  endtask

  initial begin
    t_reset();
    t_frame();
    t_mframe();
    t_txline();
    t_pool();
    t_visibility();
    t_collision();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule